// File: doc/BRIEF.md
# Stored-Address One-Hot Line Decoder

This block turns a binary address into a single active-high line out of a wider set. An address store in front of the decode has two states. While the strobe input is low, the store is open and the lines track the live address. When the strobe is raised, the store keeps the last address it saw. After that, changes on the address pins do nothing until the strobe drops again.

The top level chains basic 3-bit cells into a wider decoder. One cell decodes the upper address bits, and its outputs choose which of the lower cells may drive. Every lower cell receives the same low address bits. All cells share one strobe, so the whole address is held as a single unit.

Two global gates sit on the outputs: one active low and one active high. Lines can be high only when the low gate is 0 and the high gate is 1. The gates work independently of the address and of the store state. Together these features support strobed addressing on a shared bus.

Top module: `latdec_cascade`

## Requirements
- R1: While `strobe` is 0 and the output is gated on, line `n` is high in the same cycle in which `addr` equals `n`. Bit 0 of `addr` is the least significant bit.
- R2: On the clock edge where `strobe` is first seen high, the decoder starts using the address sampled at the previous clock edge, when `strobe` was still low.
- R3: While `strobe` stays 1, changes on `addr` leave `lines` unchanged.
- R4: Unless `gate_n` is 0 and `gate` is 1, all lines are 0, whatever the address or the store state.
- R5: If the output is gated off and then gated on again while `strobe` stays 1, the lines show the held address again.
- R6: While gated on, exactly one line is high.
- R7: Reset clears the held address to 0. So with `strobe` high from reset onward and the output gated on, line 0 is high.
- R8: All address bits are held together. Changing only the upper bits, only the lower bits, or both while `strobe` is 1 keeps the same line high.
- R9: When `strobe` returns to 0, the lines follow the live address again in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the address store |
| rst_n | input | 1 | Asynchronous reset, active low; clears the held address |
| addr | input | LO_W+HI_W (6) | Binary line address |
| strobe | input | 1 | 0: store open; 1: store holds the address |
| gate_n | input | 1 | Output gate, active low |
| gate | input | 1 | Output gate, active high |
| lines | output | 2**(LO_W+HI_W) (64) | One-hot active-high lines |

## Verification
The bench uses the default widths of three lower and three upper bits, which gives eight lower cells behind one selector cell. With these widths, every one of the 64 addresses can be visited in transparent mode. Holding tests can then change only the selector bits, only the lower bits, or both. This shows whether the two levels of storage keep the address as one unit. The bench also tries all four gate combinations, both with the store open and with it holding.

// File: rtl/latdec_pkg.sv
package latdec_pkg;
    localparam int LO_W_DEF = 3;
    localparam int HI_W_DEF = 3;

    typedef enum logic {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_e;

    function automatic gate_e gate_state(input logic g_n, input logic g);
        return (!g_n && g) ? GATE_ON : GATE_OFF;
    endfunction
endpackage

// File: rtl/latdec_store.sv
module latdec_store #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] addr_i,
    output logic [W-1:0] addr_o
);
    typedef struct packed {
        logic [W-1:0] held;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!hold) begin
            st_d.held = addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // open store: live address passes; closed: last sample is used
    assign addr_o = hold ? st_q.held : addr_i;
endmodule

// File: rtl/latdec_onehot.sv
module latdec_onehot #(
    parameter int W = 3,
    localparam int N = 1 << W
) (
    input  logic [W-1:0] addr_i,
    input  logic         gate_n,
    input  logic         gate,
    output logic [N-1:0] lines_o
);
    import latdec_pkg::*;

    gate_e st;
    assign st = gate_state(gate_n, gate);

    for (genvar i = 0; i < N; i++) begin : g_line
        assign lines_o[i] = (st == GATE_ON) && (addr_i == W'(i));
    end
endmodule

// File: rtl/latdec_cell.sv
module latdec_cell #(
    parameter int W = 3,
    localparam int N = 1 << W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] addr_i,
    input  logic         gate_n,
    input  logic         gate,
    output logic [N-1:0] lines_o
);
    logic [W-1:0] eff_addr;

    latdec_store #(.W(W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (hold),
        .addr_i (addr_i),
        .addr_o (eff_addr)
    );

    latdec_onehot #(.W(W)) u_dec (
        .addr_i  (eff_addr),
        .gate_n  (gate_n),
        .gate    (gate),
        .lines_o (lines_o)
    );
endmodule

// File: rtl/latdec_cascade.sv
module latdec_cascade #(
    parameter int LO_W = latdec_pkg::LO_W_DEF,
    parameter int HI_W = latdec_pkg::HI_W_DEF,
    localparam int ADDR_W = LO_W + HI_W,
    localparam int NSUB   = 1 << HI_W,
    localparam int NLO    = 1 << LO_W,
    localparam int LINES  = NSUB * NLO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strobe,
    input  logic              gate_n,
    input  logic              gate,
    output logic [LINES-1:0]  lines
);
    logic [NSUB-1:0] sel;

    // selector cell: upper bits, global gates, same strobe
    latdec_cell #(.W(HI_W)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (strobe),
        .addr_i  (addr[ADDR_W-1:LO_W]),
        .gate_n  (gate_n),
        .gate    (gate),
        .lines_o (sel)
    );

    for (genvar s = 0; s < NSUB; s++) begin : g_sub
        latdec_cell #(.W(LO_W)) u_sub (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold    (strobe),
            .addr_i  (addr[LO_W-1:0]),
            .gate_n  (1'b0),
            .gate    (sel[s]),
            .lines_o (lines[s*NLO +: NLO])
        );
    end
endmodule

// File: rtl/latdec_cascade_chk.sv
module latdec_cascade_chk #(
    parameter int ADDR_W = 6,
    parameter int LINES  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              strobe,
    input logic              gate_n,
    input logic              gate,
    input logic [LINES-1:0]  lines
);
    logic armed;
    logic on;
    logic [LINES-1:0] one;

    assign on  = !gate_n && gate;
    assign one = LINES'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && on) |-> (lines == (one << addr)));

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $rose(strobe) && on) |-> (lines == (one << $past(addr))));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && strobe && $past(strobe) && on && $past(on)) |-> $stable(lines));

    p_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !on |-> (lines == '0));

    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        on |-> ($countones(lines) == 1));
endmodule

bind latdec_cascade latdec_cascade_chk #(.ADDR_W(ADDR_W), .LINES(LINES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .strobe (strobe),
    .gate_n (gate_n),
    .gate   (gate),
    .lines  (lines)
);

// File: tb/test_latdec_cascade.sv
module test_latdec_cascade;
    localparam int AW = 6;
    localparam int NL = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          strobe = 1'b1;
    logic          gate_n = 1'b0;
    logic          gate = 1'b1;
    logic [NL-1:0] lines;

    int n_chk = 0;
    int n_fail = 0;
    logic          done = 1'b0;
    logic [AW-1:0] m_hold = '0;

    typedef struct {
        logic [NL-1:0] exp;
        string         tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    latdec_cascade i_latdec_cascade (
        .clk(clk), .rst_n(rst_n), .addr(addr), .strobe(strobe),
        .gate_n(gate_n), .gate(gate), .lines(lines)
    );

    // driver: drive at falling edge, push the expected lines
    task automatic step(input logic [AW-1:0] a, input logic s,
                        input logic gn, input logic g, input string tag);
        item_t it;
        logic [AW-1:0] eff;
        @(negedge clk);
        addr = a; strobe = s; gate_n = gn; gate = g;
        eff = s ? m_hold : a;
        it.exp = (!gn && g) ? (NL'(1) << eff) : '0;
        it.tag = tag;
        sb.push_back(it);
        if (!s) m_hold = a;  // captured at the coming rising edge
    endtask

    // monitor: compare midway through the low clock phase
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() != 0) begin
                item_t it;
                it = sb.pop_front();
                n_chk++;
                if (lines !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: lines=%h expected=%h", it.tag, lines, it.exp);
                end
            end
        end
    end

    initial begin
        #200_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R7: held address cleared by reset
        step(6'd37, 1'b1, 1'b0, 1'b1, "R7 reset hold");
        step(6'd12, 1'b1, 1'b0, 1'b1, "R7 reset hold");
        // R1 R6: all addresses, transparent
        for (int a = 0; a < NL; a++) step(AW'(a), 1'b0, 1'b0, 1'b1, "R1 R6 walk");
        // R4: gate combinations, open store
        step(6'd5, 1'b0, 1'b1, 1'b1, "R4 gate_n high");
        step(6'd5, 1'b0, 1'b0, 1'b0, "R4 gate low");
        step(6'd5, 1'b0, 1'b1, 1'b0, "R4 both off");
        step(6'd5, 1'b0, 1'b0, 1'b1, "R4 on");
        // R2: capture
        step(6'd42, 1'b0, 1'b0, 1'b1, "R1 before capture");
        step(6'd7,  1'b1, 1'b0, 1'b1, "R2 capture");
        // R3 R8: address changes while held
        step(6'd58, 1'b1, 1'b0, 1'b1, "R3 R8 upper only");
        step(6'd45, 1'b1, 1'b0, 1'b1, "R3 R8 lower only");
        step(6'd0,  1'b1, 1'b0, 1'b1, "R3 R8 both");
        // R4 R5: gate off and back on while held
        step(6'd63, 1'b1, 1'b1, 1'b1, "R4 held off");
        step(6'd21, 1'b1, 1'b0, 1'b0, "R4 held off");
        step(6'd9,  1'b1, 1'b0, 1'b1, "R5 held reenable");
        // R9: release
        step(6'd19, 1'b0, 1'b0, 1'b1, "R9 release");
        step(6'd50, 1'b0, 1'b0, 1'b1, "R9 follow");
        // second capture with gate off at the capture edge
        step(6'd33, 1'b1, 1'b1, 1'b0, "R4 capture gated off");
        step(6'd2,  1'b1, 1'b0, 1'b1, "R5 R2 capture shown");
        step(6'd34, 1'b1, 1'b0, 1'b1, "R3 held");
        step(6'd34, 1'b0, 1'b0, 1'b1, "R9 release");
        @(negedge clk);
        @(negedge clk);
        #8;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule